// File: doc/BRIEF.md
# SPI Boot Memory Streaming Reader

This block is the master side of a boot-from-serial-memory path. A single `start` pulse makes it select the boot memory on one fixed slave-select line and send a read command plus a start address of one, two or three bytes. It then clocks in data bytes without a break and passes them downstream one at a time on a valid/ready stream. Slave select stays low for as long as bytes keep flowing. The read ends only when `stop` is pulsed.

The serial clock comes from the system clock through a baud register, which software may overwrite. The clock runs at the system rate divided by twice the register value, so the reset value of 133 gives 500 kHz from a 133 MHz clock. The serial clock idles low. Data goes out on the falling edge and is sampled on the rising edge. If the consumer stalls, the serial clock is held low between bytes, so no received byte is ever overwritten.

Top module: `spi_boot_reader`

## Requirements
- R1: `spi_ssel_n` bit `SEL_IDX` (default 2) is low exactly while `busy` is high. Every other select bit stays high at all times.
- R2: After reset the baud register holds 133, `busy`, `spi_sck` and `rd_valid` are low, and every bit of `spi_ssel_n` is high.
- R3: `spi_sck` is low while idle. While busy, each SCK half-period lasts max(baud,1) system clocks, so a baud value of 0 acts as 1. A value written through `baud_we`/`baud_din` applies from the clock after the write.
- R4: `spi_mosi` first carries the command byte 0x03, then the address bytes most significant first, then zeros. `addr_sel` = 0 sends the low 8 bits of `start_addr`, 1 sends the low 16 bits, and 2 or 3 sends all 24 bits.
- R5: Bits go out and come in MSB first. `spi_mosi` changes only in the cycle where `spi_sck` falls, except when a read begins. `spi_miso` is sampled at each SCK rising edge.
- R6: A new data byte does not begin while the previous byte is still pending on the output. During that pause SCK is held low.
- R7: A `start` pulse while busy has no effect. `stop` while busy ends the read on the next clock: `busy` falls, select is released, SCK goes low and any pending byte is dropped.
- R8: Each data byte appears on `rd_data` with `rd_valid` on the clock after its eighth SCK rising edge. It stays stable until accepted with `rd_ready`, and bytes arrive in ascending address order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a streaming read (ignored while busy) |
| stop | input | 1 | End the streaming read |
| addr_sel | input | 2 | Address length: 0 one byte, 1 two bytes, 2/3 three bytes |
| start_addr | input | 24 | First byte address (low bytes used for short addresses) |
| baud_we | input | 1 | Write strobe for the baud register |
| baud_din | input | BAUD_W | New baud register value |
| rd_data | output | 8 | Received byte |
| rd_valid | output | 1 | `rd_data` holds an unaccepted byte |
| rd_ready | input | 1 | Consumer accepts the byte |
| busy | output | 1 | Read in progress |
| spi_sck | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data to memory |
| spi_miso | input | 1 | Serial data from memory |
| spi_ssel_n | output | SEL_W | Active-low slave selects, only bit SEL_IDX used |

## Verification
A wrong half-period count or a wrong bit counter shows up as an SCK edge in the wrong cycle. The bench compares the expected edge cycle by cycle, so the error is caught within one half-period. A wrong header state sends the wrong bit on MOSI, which is caught at the end of that byte. A lost or overwritten byte breaks the ascending data pattern that the bench memory model returns. A broken stall rule makes SCK toggle where the model keeps it low, and this is caught in the first paused cycle.

// File: rtl/spi_boot_reader.sv
module spi_boot_reader #(
  parameter int SEL_W    = 4,
  parameter int SEL_IDX  = 2,
  parameter int BAUD_W   = 16,
  parameter int BAUD_RST = 133
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              stop,
  input  logic [1:0]        addr_sel,
  input  logic [23:0]       start_addr,
  input  logic              baud_we,
  input  logic [BAUD_W-1:0] baud_din,
  output logic [7:0]        rd_data,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic              busy,
  output logic              spi_sck,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic [SEL_W-1:0]  spi_ssel_n
);
  localparam logic [7:0] READ_CMD = 8'h03;
  localparam logic [SEL_W-1:0] SEL_BIT = SEL_W'(1) << SEL_IDX;

  logic              run_q, sck_q, in_data_q, out_v_q;
  logic [BAUD_W-1:0] baud_q, cnt_q;
  logic [2:0]        bit_q;
  logic [1:0]        hdr_q, nbytes;
  logic [7:0]        tx_q, rx_q, out_q;
  logic [23:0]       addr_q, addr_aligned;

  wire [BAUD_W-1:0] half = (baud_q == '0) ? BAUD_W'(1) : baud_q;
  wire hold = !sck_q && bit_q == 3'd0 && cnt_q == '0 && in_data_q && out_v_q && !rd_ready;
  wire tick = run_q && !hold && (cnt_q >= half - BAUD_W'(1));
  wire rise = tick && !sck_q;
  wire fall = tick && sck_q;
  wire last = bit_q == 3'd7;
  wire load = rise && last && in_data_q;

  always_comb begin
    case (addr_sel)
      2'd0:    nbytes = 2'd1;
      2'd1:    nbytes = 2'd2;
      default: nbytes = 2'd3;
    endcase
    case (nbytes)
      2'd1:    addr_aligned = {start_addr[7:0], 16'h0};
      2'd2:    addr_aligned = {start_addr[15:0], 8'h0};
      default: addr_aligned = start_addr;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) baud_q <= BAUD_W'(BAUD_RST);
    else if (baud_we) baud_q <= baud_din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= 1'b0; sck_q <= 1'b0; in_data_q <= 1'b0; out_v_q <= 1'b0;
      cnt_q <= '0; bit_q <= '0; hdr_q <= '0;
      tx_q <= '0; rx_q <= '0; out_q <= '0; addr_q <= '0;
    end else if (run_q && stop) begin
      run_q <= 1'b0; sck_q <= 1'b0; out_v_q <= 1'b0;
    end else if (!run_q) begin
      if (start) begin
        run_q <= 1'b1; sck_q <= 1'b0; cnt_q <= '0; bit_q <= '0;
        in_data_q <= 1'b0; hdr_q <= nbytes; tx_q <= READ_CMD; addr_q <= addr_aligned;
      end
    end else begin
      if (tick) cnt_q <= '0;
      else if (!hold) cnt_q <= cnt_q + BAUD_W'(1);
      if (tick) sck_q <= ~sck_q;
      if (rise) rx_q <= {rx_q[6:0], spi_miso};
      if (fall) begin
        bit_q <= bit_q + 3'd1;
        if (!last) tx_q <= {tx_q[6:0], 1'b0};
        else if (hdr_q != 2'd0) begin
          tx_q <= addr_q[23:16]; addr_q <= addr_q << 8; hdr_q <= hdr_q - 2'd1;
        end else begin
          tx_q <= 8'h00; in_data_q <= 1'b1;
        end
      end
      if (load) begin
        out_q <= {rx_q[6:0], spi_miso}; out_v_q <= 1'b1;
      end else if (rd_ready) out_v_q <= 1'b0;
    end
  end

  assign busy       = run_q;
  assign spi_sck    = sck_q;
  assign spi_mosi   = run_q & tx_q[7];
  assign spi_ssel_n = run_q ? ~SEL_BIT : '1;
  assign rd_data    = out_q;
  assign rd_valid   = out_v_q;
endmodule

// File: rtl/spi_boot_reader_chk.sv
module spi_boot_reader_chk #(
  parameter int SEL_W   = 4,
  parameter int SEL_IDX = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             stop,
  input logic             rd_ready,
  input logic             busy,
  input logic             spi_sck,
  input logic             spi_mosi,
  input logic [SEL_W-1:0] spi_ssel_n,
  input logic             rd_valid,
  input logic [7:0]       rd_data
);
  AST_SEL_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(~spi_ssel_n) <= 1) && (spi_ssel_n[SEL_IDX] == !busy)); // R1
  AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !spi_sck); // R3
  AST_MOSI_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) && !$fell(spi_sck) |-> $stable(spi_mosi)); // R5
  AST_BYTE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready && !stop |=> rd_valid && $stable(rd_data)); // R8
  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    busy && stop |=> !busy && !spi_sck && !rd_valid); // R7
endmodule

bind spi_boot_reader spi_boot_reader_chk #(.SEL_W(SEL_W), .SEL_IDX(SEL_IDX)) chk_i (
  .clk(clk), .rst_n(rst_n), .stop(stop), .rd_ready(rd_ready), .busy(busy),
  .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_ssel_n(spi_ssel_n),
  .rd_valid(rd_valid), .rd_data(rd_data)
);

// File: tb/spi_boot_reader_tb_top.sv
module spi_boot_reader_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, stop = 0, baud_we = 0, rd_ready = 0, spi_miso = 0;
  logic [1:0] addr_sel = 0;
  logic [23:0] start_addr = 0;
  logic [15:0] baud_din = 0;
  logic [7:0] rd_data;
  logic rd_valid, busy, spi_sck, spi_mosi;
  logic [3:0] spi_ssel_n;

  always #4 clk = ~clk;

  spi_boot_reader dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .stop(stop), .addr_sel(addr_sel),
    .start_addr(start_addr), .baud_we(baud_we), .baud_din(baud_din),
    .rd_data(rd_data), .rd_valid(rd_valid), .rd_ready(rd_ready), .busy(busy),
    .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_ssel_n(spi_ssel_n)
  );

  int vecs = 0, bad = 0, cyc = 0, accepted = 0, rdy_mode = 0;

  function automatic int mem_byte(int a);
    return ((a * 29) ^ (a >> 8) ^ 8'h5A) & 255;
  endfunction

  task automatic chk(string tag, int act, int exp);
    vecs++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // behavioural reference
  int m_run, m_sck, m_cnt, m_bit, m_byte, m_nhdr, m_addr, m_outv, m_outd, m_baud;
  always @(posedge clk) begin
    int eff; bit hold, load, fire;
    cyc++;
    if (!rst_n) begin
      m_run = 0; m_sck = 0; m_outv = 0; m_outd = 0; m_baud = 133;
    end else begin
      eff = (m_baud == 0) ? 1 : m_baud;
      load = 0;
      if (m_run && stop) begin
        m_run = 0; m_sck = 0; m_outv = 0;
      end else if (!m_run) begin
        if (start) begin
          m_run = 1; m_sck = 0; m_cnt = 0; m_bit = 0; m_byte = 0;
          m_nhdr = 1 + ((addr_sel == 0) ? 1 : (addr_sel == 1) ? 2 : 3);
          m_addr = start_addr & ((1 << (8 * (m_nhdr - 1))) - 1);
        end
      end else begin
        fire = m_outv && rd_ready;
        hold = !m_sck && m_bit == 0 && m_cnt == 0 && m_byte >= m_nhdr && m_outv && !rd_ready;
        if (!hold) begin
          if (m_cnt >= eff - 1) begin
            m_cnt = 0;
            if (!m_sck) begin
              m_sck = 1;
              if (m_bit == 7 && m_byte >= m_nhdr) load = 1;
            end else begin
              m_sck = 0; m_bit = (m_bit + 1) % 8;
              if (m_bit == 0) m_byte++;
            end
          end else m_cnt++;
        end
        if (load) begin
          m_outv = 1; m_outd = mem_byte(m_addr + m_byte - m_nhdr);
        end else if (fire) begin
          m_outv = 0; accepted++;
        end
      end
      if (baud_we) m_baud = baud_din;
    end
  end

  // serial memory model and header capture
  int rcount = 0; logic [7:0] hsr = 0; logic prev_sck = 0;
  always @(negedge clk) begin
    int idx, hb;
    if (spi_ssel_n[2]) begin
      rcount = 0;
    end else if (spi_sck && !prev_sck) begin
      hsr = {hsr[6:0], spi_mosi};
      if (rcount % 8 == 7 && rcount / 8 < m_nhdr) begin
        hb = rcount / 8;
        chk("R4 header byte", hsr, hb == 0 ? 8'h03 : (m_addr >> (8 * (m_nhdr - 1 - hb))) & 255);
      end
      rcount++;
    end
    prev_sck = spi_sck;
    idx = rcount - 8 * m_nhdr;
    spi_miso = (!spi_ssel_n[2] && idx >= 0) ? mem_byte(m_addr + idx / 8) >> (7 - idx % 8) : 1'b0;
  end

  // per-cycle compare and ready driver
  bit comparing = 0;
  always @(negedge clk) begin
    if (comparing) begin
      chk("R1 select", spi_ssel_n, m_run ? 4'hB : 4'hF);
      chk("R7 busy", busy, m_run);
      chk("R3 R6 sck", spi_sck, m_sck);
      chk("R8 valid", rd_valid, m_outv);
      if (m_outv) chk("R5 R8 data", rd_data, m_outd);
    end
    case (rdy_mode)
      0: rd_ready <= 1'b1;
      1: rd_ready <= (cyc % 23) < 3;
      default: rd_ready <= 1'b0;
    endcase
  end

  task automatic go(int sel, int addr);
    @(negedge clk); addr_sel = 2'(sel); start_addr = 24'(addr); start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic wait_bytes(int n);
    int target = accepted + n;
    while (accepted < target) @(negedge clk);
  endtask

  task automatic halt();
    @(negedge clk); stop = 1;
    @(negedge clk); stop = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R2 busy", busy, 0);
    chk("R2 sck", spi_sck, 0);
    chk("R2 valid", rd_valid, 0);
    chk("R2 select", spi_ssel_n, 4'hF);
    rst_n = 1;
    comparing = 1;
    // default divider, 24-bit address
    rdy_mode = 0;
    go(2, 24'h12_3456);
    go(0, 24'hFF);          // R7 start while busy ignored
    wait_bytes(3);
    halt();
    // divider 2, 8-bit address
    @(negedge clk); baud_din = 2; baud_we = 1;
    @(negedge clk); baud_we = 0;
    go(0, 24'hAB_CDEF);
    wait_bytes(6);
    halt();
    // divider 0 acts as 1, 16-bit address, sporadic ready (R6)
    @(negedge clk); baud_din = 0; baud_we = 1;
    @(negedge clk); baud_we = 0;
    rdy_mode = 1;
    go(1, 24'h00_7FFE);
    wait_bytes(10);
    // long stall: no consumer (R6)
    rdy_mode = 2;
    repeat (200) @(negedge clk);
    rdy_mode = 1;
    wait_bytes(4);
    // stop mid-byte with byte pending (R7)
    rdy_mode = 2;
    repeat (37) @(negedge clk);
    halt();
    repeat (5) @(negedge clk);
    chk("R7 idle after stop", busy, 0);
    // divider 3, 3-byte address selected by code 3
    @(negedge clk); baud_din = 3; baud_we = 1;
    @(negedge clk); baud_we = 0;
    rdy_mode = 0;
    go(3, 24'hFE_DCBA);
    wait_bytes(4);
    halt();
    repeat (4) @(negedge clk);
    comparing = 0;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++; vecs++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule